// File: doc/BRIEF.md
# Host Bridge Configuration Space with Upper-BIOS Shadow Decoder

This block holds the 256-byte configuration space of a host bridge and turns two of its bytes into memory routing attributes for the upper BIOS window. A byte-wide port reads and writes that space. Identification bytes are fixed. The command and status bytes, and every byte from offset 0x40 upward, accept writes.

The window is 64 KB, starting at 0xE0000. It is split into four 16 KB segments. Each segment has its own enable bit, and one shared two-bit mode field selects where reads and writes go for all enabled segments. "Internal" means the shadow DRAM copy and "external" means the bus or ROM.

For each segment the block drives registered read-internal and write-internal flags. A combinational lookup port takes a physical address and returns the flags of the segment that covers it. The configuration port is plain control: no handshake, and every access completes in the cycle it is presented.

Top module: `hb_shadow_decoder`

## Requirements
- R1: After reset the bytes read as follows, and every other byte reads 0x00:
  - offset 0x00 = 0x39, offset 0x01 = 0x10
  - offset 0x02 = 0x06, offset 0x03 = 0x04
  - offset 0x04 = 0x07
  - offset 0x06 = 0x80, offset 0x07 = 0x02
  - offset 0x0B = 0x06
- R2: A write at offsets 0x04 through 0x07, or at 0x40 through 0xFF, stores the write data. The new value is readable from the cycle after the capturing clock edge.
- R3: A write at offsets 0x00 through 0x03 or 0x08 through 0x3F leaves the stored byte unchanged.
- R4: `cfg_rdata` shows the stored byte at `cfg_ofs` combinationally, at any offset, in the same cycle.
- R5: Segment n (n = 0..3) covers 0xE0000 + n*0x4000 up to 0xE0000 + n*0x4000 + 0x3FFF. It is enabled by bit 4+n of byte 0x54, and bits 3:0 of that byte have no effect.
- R6: Bits 6:5 of byte 0x53 set the mode of every enabled segment. Bits 4:0 and bit 7 of that byte have no effect. The codes are:
  - 00: read external, write internal
  - 01: both external
  - 10: both internal
  - 11: read internal, write external
- R7: A segment whose enable bit is clear reports read external and write external (both flags 0), whatever the mode field holds.
- R8: `seg_rd_int`/`seg_wr_int` change only on the clock edge that follows the edge capturing a write to 0x53 or 0x54. They hold their value otherwise, including across writes to other offsets.
- R9: `lk_rd_int`/`lk_wr_int` equal the flags of the segment containing `lk_addr`. They are 0/0 for any address outside 0xE0000..0xEFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ofs | input | 8 | Configuration byte offset |
| cfg_we | input | 1 | Write strobe, sampled on the rising edge |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Stored byte at `cfg_ofs` |
| seg_rd_int | output | 4 | Per-segment read-internal flags, bit n = segment n |
| seg_wr_int | output | 4 | Per-segment write-internal flags, bit n = segment n |
| lk_addr | input | 20 | Physical address to classify |
| lk_rd_int | output | 1 | Read-internal flag for `lk_addr` |
| lk_wr_int | output | 1 | Write-internal flag for `lk_addr` |

## Verification
Read data is due in the same cycle as the offset. A written byte is due in the cycle after the edge that captures the write. The segment flags, and any lookup that depends on them, are due one edge later still. The scoreboard tags each expected item with the cycle number in which it must hold, and the monitor compares it at the falling edge of exactly that cycle. R8 is covered by expecting the old flags in the intermediate cycle and the new ones in the next.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  localparam int CFG_OFS_W    = 8;
  localparam int CFG_DEPTH    = 1 << CFG_OFS_W;
  localparam logic [7:0] ENA_OFS  = 8'h54;
  localparam logic [7:0] MODE_OFS = 8'h53;
  localparam int SEG_ENA_LSB  = 4;
  localparam int MODE_LSB     = 5;

  typedef enum logic [1:0] {
    MODE_RDEXT_WRINT = 2'b00,
    MODE_BOTH_EXT    = 2'b01,
    MODE_BOTH_INT    = 2'b10,
    MODE_RDINT_WREXT = 2'b11
  } shadow_mode_e;

  function automatic logic cfg_writable(input logic [7:0] o);
    return (o >= 8'h04 && o <= 8'h07) || (o >= 8'h40);
  endfunction

  function automatic logic [7:0] cfg_reset_val(input logic [7:0] o);
    case (o)
      8'h00:   return 8'h39;
      8'h01:   return 8'h10;
      8'h02:   return 8'h06;
      8'h03:   return 8'h04;
      8'h04:   return 8'h07;
      8'h06:   return 8'h80;
      8'h07:   return 8'h02;
      8'h0B:   return 8'h06;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/hbs_cfg_space.sv
module hbs_cfg_space
  import hbs_pkg::*;
#(
  parameter int SEG_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CFG_OFS_W-1:0] ofs,
  input  logic                 we,
  input  logic [7:0]           wdata,
  output logic [7:0]           rdata,
  output logic [SEG_COUNT-1:0] seg_ena,
  output shadow_mode_e         mode
);
  logic [7:0] cfg_b [CFG_DEPTH];

  // Read-only offsets are never written, so they keep their reset constant.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CFG_DEPTH; i++)
        cfg_b[i] <= cfg_reset_val(CFG_OFS_W'(i));
    end else if (we && cfg_writable(ofs)) begin
      cfg_b[ofs] <= wdata;
    end
  end

  assign rdata   = cfg_b[ofs];
  assign seg_ena = cfg_b[ENA_OFS][SEG_ENA_LSB +: SEG_COUNT];
  assign mode    = shadow_mode_e'(cfg_b[MODE_OFS][MODE_LSB +: 2]);
endmodule

// File: rtl/hbs_seg_attr.sv
module hbs_seg_attr
  import hbs_pkg::*;
#(
  parameter int SEG_COUNT = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEG_COUNT-1:0] seg_ena,
  input  shadow_mode_e         mode,
  output logic [SEG_COUNT-1:0] rd_int,
  output logic [SEG_COUNT-1:0] wr_int
);
  logic m_rd, m_wr;
  logic [SEG_COUNT-1:0] rd_d, wr_d;

  always_comb begin
    case (mode)
      MODE_RDEXT_WRINT: begin m_rd = 1'b0; m_wr = 1'b1; end
      MODE_BOTH_EXT:    begin m_rd = 1'b0; m_wr = 1'b0; end
      MODE_BOTH_INT:    begin m_rd = 1'b1; m_wr = 1'b1; end
      default:          begin m_rd = 1'b1; m_wr = 1'b0; end
    endcase
  end

  for (genvar g = 0; g < SEG_COUNT; g++) begin : g_seg
    // A disabled segment falls back to external for both directions.
    assign rd_d[g] = seg_ena[g] & m_rd;
    assign wr_d[g] = seg_ena[g] & m_wr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_int <= '0;
      wr_int <= '0;
    end else begin
      rd_int <= rd_d;
      wr_int <= wr_d;
    end
  end
endmodule

// File: rtl/hbs_addr_lookup.sv
module hbs_addr_lookup #(
  parameter int                 ADDR_W    = 20,
  parameter int                 SEG_COUNT = 4,
  parameter int                 SEG_LOG2  = 14,
  parameter logic [ADDR_W-1:0]  SEG_BASE  = 20'hE0000
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic [SEG_COUNT-1:0] rd_int,
  input  logic [SEG_COUNT-1:0] wr_int,
  output logic                 lk_rd,
  output logic                 lk_wr
);
  localparam int IDX_W = (SEG_COUNT > 1) ? $clog2(SEG_COUNT) : 1;

  logic [ADDR_W:0] off, seg_pos;
  logic            in_rng;
  logic [IDX_W-1:0] idx;

  assign off     = {1'b0, addr} - {1'b0, SEG_BASE};
  assign seg_pos = off >> SEG_LOG2;
  assign in_rng  = (addr >= SEG_BASE) && (seg_pos < (ADDR_W+1)'(SEG_COUNT));
  assign idx     = seg_pos[IDX_W-1:0];

  always_comb begin
    lk_rd = 1'b0;
    lk_wr = 1'b0;
    if (in_rng) begin
      lk_rd = rd_int[idx];
      lk_wr = wr_int[idx];
    end
  end
endmodule

// File: rtl/hb_shadow_decoder.sv
module hb_shadow_decoder
  import hbs_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                SEG_COUNT = 4,
  parameter int                SEG_LOG2  = 14,
  parameter logic [ADDR_W-1:0] SEG_BASE  = 20'hE0000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           cfg_ofs,
  input  logic                 cfg_we,
  input  logic [7:0]           cfg_wdata,
  output logic [7:0]           cfg_rdata,
  output logic [SEG_COUNT-1:0] seg_rd_int,
  output logic [SEG_COUNT-1:0] seg_wr_int,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_rd_int,
  output logic                 lk_wr_int
);
  logic [SEG_COUNT-1:0] seg_ena;
  shadow_mode_e         mode;

  hbs_cfg_space #(.SEG_COUNT(SEG_COUNT)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ofs(cfg_ofs), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .seg_ena(seg_ena), .mode(mode)
  );

  hbs_seg_attr #(.SEG_COUNT(SEG_COUNT)) u_attr (
    .clk(clk), .rst_n(rst_n), .seg_ena(seg_ena), .mode(mode),
    .rd_int(seg_rd_int), .wr_int(seg_wr_int)
  );

  hbs_addr_lookup #(
    .ADDR_W(ADDR_W), .SEG_COUNT(SEG_COUNT), .SEG_LOG2(SEG_LOG2), .SEG_BASE(SEG_BASE)
  ) u_lk (
    .addr(lk_addr), .rd_int(seg_rd_int), .wr_int(seg_wr_int),
    .lk_rd(lk_rd_int), .lk_wr(lk_wr_int)
  );
endmodule

// File: rtl/hbs_checker.sv
module hbs_checker
  import hbs_pkg::*;
#(
  parameter int                ADDR_W    = 20,
  parameter int                SEG_COUNT = 4,
  parameter int                SEG_LOG2  = 14,
  parameter logic [ADDR_W-1:0] SEG_BASE  = 20'hE0000
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           cfg_ofs,
  input logic                 cfg_we,
  input logic [7:0]           cfg_wdata,
  input logic [7:0]           cfg_rdata,
  input logic [SEG_COUNT-1:0] seg_rd_int,
  input logic [SEG_COUNT-1:0] seg_wr_int,
  input logic [SEG_COUNT-1:0] seg_ena,
  input logic [ADDR_W-1:0]    lk_addr,
  input logic                 lk_rd_int,
  input logic                 lk_wr_int
);
  localparam logic [ADDR_W:0] SPAN = (ADDR_W+1)'(SEG_COUNT) << SEG_LOG2;
  logic [ADDR_W:0] rel;
  logic            win;
  logic            attr_wr;

  assign rel     = {1'b0, lk_addr} - {1'b0, SEG_BASE};
  assign win     = (lk_addr >= SEG_BASE) && (rel < SPAN);
  assign attr_wr = cfg_we && (cfg_ofs == ENA_OFS || cfg_ofs == MODE_OFS);

  a_r1_vendor_fixed: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_ofs == 8'h00 |-> cfg_rdata == 8'h39);

  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && cfg_writable(cfg_ofs) |=>
      (cfg_ofs != $past(cfg_ofs)) || (cfg_rdata == $past(cfg_wdata)));

  a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we && !cfg_writable(cfg_ofs) |=>
      (cfg_ofs != $past(cfg_ofs)) || (cfg_rdata == $past(cfg_rdata)));

  a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_rd_int != $past(seg_rd_int) || seg_wr_int != $past(seg_wr_int))
      |-> $past(attr_wr, 2));

  a_r9_outside: assert property (@(posedge clk) disable iff (!rst_n)
    !win |-> !lk_rd_int && !lk_wr_int);

  for (genvar i = 0; i < SEG_COUNT; i++) begin : g_chk
    a_r7_disabled_ext: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(seg_ena[i]) |-> !seg_rd_int[i] && !seg_wr_int[i]);

    a_r9_seg_match: assert property (@(posedge clk) disable iff (!rst_n)
      win && ((rel >> SEG_LOG2) == (ADDR_W+1)'(i)) |->
        lk_rd_int == seg_rd_int[i] && lk_wr_int == seg_wr_int[i]);
  end
endmodule

bind hb_shadow_decoder hbs_checker #(
  .ADDR_W(ADDR_W), .SEG_COUNT(SEG_COUNT), .SEG_LOG2(SEG_LOG2), .SEG_BASE(SEG_BASE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_ofs(cfg_ofs), .cfg_we(cfg_we),
  .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .seg_rd_int(seg_rd_int),
  .seg_wr_int(seg_wr_int), .seg_ena(seg_ena), .lk_addr(lk_addr),
  .lk_rd_int(lk_rd_int), .lk_wr_int(lk_wr_int)
);

// File: tb/hb_shadow_decoder_tb.sv
module hb_shadow_decoder_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_ofs = 8'h00;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rdata;
  logic [3:0] seg_rd_int, seg_wr_int;
  logic [19:0] lk_addr = 20'h00000;
  logic       lk_rd_int, lk_wr_int;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  // Scoreboard queues: sample cycle, kind (0 read, 1 segment flags, 2 lookup), value, tag.
  int         q_cyc[$];
  int         q_kind[$];
  logic [7:0] q_exp[$];
  string      q_req[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hb_shadow_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_ofs(cfg_ofs), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .seg_rd_int(seg_rd_int),
    .seg_wr_int(seg_wr_int), .lk_addr(lk_addr), .lk_rd_int(lk_rd_int),
    .lk_wr_int(lk_wr_int)
  );

  // Monitor: compare every item due in this cycle at the falling edge.
  always @(negedge clk) begin
    while (q_cyc.size() > 0 && q_cyc[0] == cyc) begin
      logic [7:0] act;
      int k;
      k = q_kind.pop_front();
      case (k)
        0:       act = cfg_rdata;
        1:       act = {seg_rd_int, seg_wr_int};
        default: act = {6'b0, lk_rd_int, lk_wr_int};
      endcase
      checks++;
      if (act !== q_exp[0]) begin
        errors++;
        $display("FAIL %s kind %0d: actual %02h expected %02h", q_req[0], k, act, q_exp[0]);
      end
      void'(q_cyc.pop_front());
      void'(q_exp.pop_front());
      void'(q_req.pop_front());
    end
  end

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic push(input int kind, input logic [7:0] e, input string req);
    q_cyc.push_back(cyc);
    q_kind.push_back(kind);
    q_exp.push_back(e);
    q_req.push_back(req);
  endtask

  task automatic wr(input logic [7:0] o, input logic [7:0] d);
    cfg_ofs = o; cfg_wdata = d; cfg_we = 1'b1;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic exp_rd(input logic [7:0] o, input logic [7:0] e, input string req);
    cfg_ofs = o;
    push(0, e, req);
    tick();
  endtask

  task automatic exp_seg(input logic [3:0] rd, input logic [3:0] wrf, input string req);
    push(1, {rd, wrf}, req);
    tick();
  endtask

  task automatic exp_lk(input logic [19:0] a, input logic r, input logic w, input string req);
    lk_addr = a;
    push(2, {6'b0, r, w}, req);
    tick();
  endtask

  // Write a shadow control byte, then expect the new flags one edge later.
  task automatic cfg_seg(input logic [7:0] o, input logic [7:0] d,
                         input logic [3:0] rd, input logic [3:0] wrf, input string req);
    wr(o, d);
    tick();
    exp_seg(rd, wrf, req);
  endtask

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1 reset image
    exp_rd(8'h00, 8'h39, "R1"); exp_rd(8'h01, 8'h10, "R1");
    exp_rd(8'h02, 8'h06, "R1"); exp_rd(8'h03, 8'h04, "R1");
    exp_rd(8'h04, 8'h07, "R1"); exp_rd(8'h05, 8'h00, "R1");
    exp_rd(8'h06, 8'h80, "R1"); exp_rd(8'h07, 8'h02, "R1");
    exp_rd(8'h09, 8'h00, "R1"); exp_rd(8'h0A, 8'h00, "R1");
    exp_rd(8'h0B, 8'h06, "R1"); exp_rd(8'h54, 8'h00, "R1");
    exp_rd(8'hFF, 8'h00, "R1");
    exp_seg(4'b0000, 4'b0000, "R1");
    exp_lk(20'hE0000, 1'b0, 1'b0, "R1");

    // R3 ignored offsets, read back the same byte right after the write
    wr(8'h00, 8'hAA); exp_rd(8'h00, 8'h39, "R3");
    wr(8'h03, 8'hAA); exp_rd(8'h03, 8'h04, "R3");
    wr(8'h08, 8'h5C); exp_rd(8'h08, 8'h00, "R3");
    wr(8'h0B, 8'h11); exp_rd(8'h0B, 8'h06, "R3");
    wr(8'h3F, 8'h77); exp_rd(8'h3F, 8'h00, "R3");

    // R2 / R4 writable offsets, readable the cycle after the capture edge
    wr(8'h04, 8'h5A); exp_rd(8'h04, 8'h5A, "R2");
    wr(8'h07, 8'hC3); exp_rd(8'h07, 8'hC3, "R2");
    wr(8'h40, 8'h81); exp_rd(8'h40, 8'h81, "R2");
    wr(8'hFF, 8'h3E); exp_rd(8'hFF, 8'h3E, "R2");
    exp_rd(8'h40, 8'h81, "R4");

    // R8 flags lag one extra edge; R6 mode 00 with all segments enabled
    wr(8'h54, 8'hF0);
    exp_seg(4'b0000, 4'b0000, "R8");
    exp_seg(4'b0000, 4'b1111, "R6");
    cfg_seg(8'h53, 8'h20, 4'b0000, 4'b0000, "R6");
    cfg_seg(8'h53, 8'h40, 4'b1111, 4'b1111, "R6");
    cfg_seg(8'h53, 8'h60, 4'b1111, 4'b0000, "R6");

    // R7 disabled segments stay external in every mode
    cfg_seg(8'h54, 8'h50, 4'b0101, 4'b0000, "R7");
    cfg_seg(8'h53, 8'h40, 4'b0101, 4'b0101, "R7");
    cfg_seg(8'h53, 8'h9F, 4'b0000, 4'b0101, "R6");  // only bits 6:5 count
    cfg_seg(8'h54, 8'h0F, 4'b0000, 4'b0000, "R5");  // low nibble enables nothing

    // R5 / R9 lookup with segments 0 and 3 enabled, mode both internal
    cfg_seg(8'h53, 8'h40, 4'b0000, 4'b0000, "R7");
    cfg_seg(8'h54, 8'h90, 4'b1001, 4'b1001, "R5");
    exp_lk(20'hE0000, 1'b1, 1'b1, "R9");
    exp_lk(20'hE3FFF, 1'b1, 1'b1, "R5");
    exp_lk(20'hE4000, 1'b0, 1'b0, "R5");
    exp_lk(20'hEBFFF, 1'b0, 1'b0, "R5");
    exp_lk(20'hEC000, 1'b1, 1'b1, "R5");
    exp_lk(20'hEFFFF, 1'b1, 1'b1, "R9");
    exp_lk(20'hF0000, 1'b0, 1'b0, "R9");
    exp_lk(20'hDFFFF, 1'b0, 1'b0, "R9");

    // R8 writes elsewhere leave flags untouched
    wr(8'h52, 8'hFF);
    exp_seg(4'b1001, 4'b1001, "R8");
    exp_seg(4'b1001, 4'b1001, "R8");

    repeat (2) tick();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule